// File: doc/BRIEF.md
# Instruction Fetch and Decode Sequencer

This block is the control sequencer of a small accumulator machine. It brings in one 16-bit instruction at a time through a chain of register transfers. First the program counter goes into the memory address register. Then the counter steps by one while a read goes out to a synchronous memory. The returned word is held in the memory data register and then copied into the current instruction register. The sequencer then splits that register into an opcode byte and an operand byte. It hands both to an external execute stage with a one-cycle start pulse, and waits for a done pulse from that stage.

Between two whole instructions the sequencer looks at a single interrupt request line. When a request is pending and not masked, the sequencer parks the program counter in a shadow register, jumps to a fixed handler address and masks further requests. A dedicated return opcode in the handler brings back the parked counter and lifts the mask. The sequencer handles the return opcode itself; the execute stage never sees it. The ALU and all operand addressing belong to the execute stage.

Top module: `fetchDecodeSeq`

## Requirements
- R1: A synchronous reset clears the program counter, MAR, MDR and CIR to zero. It also clears the interrupt mask, holds exStart low, and leaves the sequencer ready to begin a fetch.
- R2: The first step of every fetch copies the program counter into the MAR. In the following cycle memRdEn is high for one cycle with memAddr equal to the MAR.
- R3: The program counter increases by one in the cycle the read strobe is high, before the read data arrives. It is 8 bits wide and wraps from 255 to 0.
- R4: The MDR takes memRdData on the clock edge one cycle after the read strobe. On the next edge the CIR takes the MDR.
- R5: In the cycle after the CIR is loaded, exStart is high for exactly one cycle. exOpcode then carries CIR bits 15:8 and exOperand carries CIR bits 7:0.
- R6: After exStart the sequencer waits, with no memory read and no new start, until exDone is high. Only then does it go on.
- R7: irqReq is sampled only in the one cycle after exDone or after a return opcode. If it is high and the mask is clear, the next fetch comes from address 8'hF0. The program counter that would have been fetched is saved, and the mask is set.
- R8: While the mask is set, irqReq has no effect and the program runs on in order.
- R9: An instruction whose opcode is 8'hFF is not passed to the execute stage. It loads the program counter with the saved value and clears the mask, so fetching resumes where the program was interrupted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| memRdEn | output | 1 | Memory read strobe |
| memAddr | output | 8 | Memory read address (MAR) |
| memRdData | input | 16 | Read data, valid one cycle after the strobe |
| irqReq | input | 1 | Interrupt request level |
| exStart | output | 1 | One-cycle start pulse to the execute stage |
| exOpcode | output | 8 | Opcode byte of the current instruction |
| exOperand | output | 8 | Operand byte of the current instruction |
| exDone | input | 1 | Completion pulse from the execute stage |
| pcOut | output | 8 | Program counter |
| marOut | output | 8 | Memory address register |
| mdrOut | output | 16 | Memory data register |
| cirOut | output | 16 | Current instruction register |
| irqMasked | output | 1 | Interrupt mask state |

## Verification
The hardest case to reach is a request that is still held high at the boundary inside the handler, where the mask has to suppress it. The other half of that case is a second request after the return, which must be taken again. The stimulus raises irqReq while a chosen instruction is executing, so the next boundary enters the handler. It keeps the line high through the handler's first boundary and drops it only before the return. A later instruction then raises it a second time. A separate run walks the program counter through all 256 addresses to reach the wrap from 255 to 0.

// File: rtl/fdsPkg.sv
package fdsPkg;
  typedef enum logic [2:0] {
    PH_MAR, PH_READ, PH_MDR, PH_CIR, PH_DECODE, PH_EXEC, PH_BOUND
  } seqPhase_t;

  typedef struct packed {
    logic loadMar;
    logic incPc;
    logic loadMdr;
    logic loadCir;
    logic irqEnter;
    logic retire;
  } seqStrobe_t;
endpackage

// File: rtl/fdsControl.sv
module fdsControl
  import fdsPkg::*;
#(
  parameter int OPC_W  = 8,
  parameter logic [OPC_W-1:0] RET_OP = 8'hFF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  input  logic             exDone,
  input  logic             irqReq,
  input  logic             irqMasked,
  output seqStrobe_t       stb,
  output logic             memRdEn,
  output logic             exStart
);
  seqPhase_t phase, phaseNext;

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_MAR;
    else     phase <= phaseNext;
  end

  always_comb begin
    stb       = '0;
    memRdEn   = 1'b0;
    exStart   = 1'b0;
    phaseNext = phase;
    case (phase)
      PH_MAR: begin
        stb.loadMar = 1'b1;
        phaseNext   = PH_READ;
      end
      PH_READ: begin
        stb.incPc = 1'b1;
        memRdEn   = 1'b1;
        phaseNext = PH_MDR;
      end
      PH_MDR: begin
        stb.loadMdr = 1'b1;
        phaseNext   = PH_CIR;
      end
      PH_CIR: begin
        stb.loadCir = 1'b1;
        phaseNext   = PH_DECODE;
      end
      PH_DECODE: begin
        if (opcode == RET_OP) begin
          stb.retire = 1'b1;
          phaseNext  = PH_BOUND;
        end else begin
          exStart   = 1'b1;
          phaseNext = PH_EXEC;
        end
      end
      PH_EXEC: begin
        if (exDone) phaseNext = PH_BOUND;
      end
      PH_BOUND: begin
        stb.irqEnter = irqReq && !irqMasked;
        phaseNext    = PH_MAR;
      end
      default: phaseNext = PH_MAR;
    endcase
  end

  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
    exStart |=> !exStart); // R5
  AST_EXEC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_EXEC && !exDone) |=> (!memRdEn && !exStart)); // R6
  AST_READ_AFTER_MAR: assert property (@(posedge clk) disable iff (rst)
    stb.loadMar |=> memRdEn); // R2
endmodule

// File: rtl/fdsDatapath.sv
module fdsDatapath
  import fdsPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 16,
  parameter int OPC_W  = 8,
  parameter logic [ADDR_W-1:0] IRQ_VEC = 8'hF0,
  localparam int OPD_W = WORD_W - OPC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobe_t        stb,
  input  logic [WORD_W-1:0] memRdData,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] mar,
  output logic [WORD_W-1:0] mdr,
  output logic [WORD_W-1:0] cir,
  output logic              masked,
  output logic [OPC_W-1:0]  opcode,
  output logic [OPD_W-1:0]  operand
);
  logic [ADDR_W-1:0] pcShadow;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc       <= '0;
      mar      <= '0;
      mdr      <= '0;
      cir      <= '0;
      pcShadow <= '0;
      masked   <= 1'b0;
    end else begin
      if (stb.loadMar) mar <= pc;
      if (stb.incPc)   pc  <= pc + 1'b1;
      if (stb.loadMdr) mdr <= memRdData;
      if (stb.loadCir) cir <= mdr;
      if (stb.irqEnter) begin
        pcShadow <= pc;
        pc       <= IRQ_VEC;
        masked   <= 1'b1;
      end
      if (stb.retire) begin
        pc     <= pcShadow;
        masked <= 1'b0;
      end
    end
  end

  assign opcode  = cir[WORD_W-1 -: OPC_W];
  assign operand = cir[OPD_W-1:0];

  AST_MAR_FROM_PC: assert property (@(posedge clk) disable iff (rst)
    stb.loadMar |=> (mar == $past(pc))); // R2
  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    stb.incPc |=> (pc == $past(pc) + 1'b1)); // R3
  AST_MDR_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    stb.loadMdr |=> (mdr == $past(memRdData))); // R4
  AST_CIR_FROM_MDR: assert property (@(posedge clk) disable iff (rst)
    stb.loadCir |=> (cir == $past(mdr))); // R4
  AST_IRQ_ENTRY: assert property (@(posedge clk) disable iff (rst)
    stb.irqEnter |=> (pc == IRQ_VEC && masked)); // R7
  AST_RETURN: assert property (@(posedge clk) disable iff (rst)
    stb.retire |=> (pc == $past(pcShadow) && !masked)); // R9
endmodule

// File: rtl/fetchDecodeSeq.sv
module fetchDecodeSeq
  import fdsPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 16,
  parameter int OPC_W  = 8,
  parameter logic [ADDR_W-1:0] IRQ_VEC = 8'hF0,
  parameter logic [OPC_W-1:0]  RET_OP  = 8'hFF,
  localparam int OPD_W = WORD_W - OPC_W
) (
  input  logic              clk,
  input  logic              rst,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [WORD_W-1:0] memRdData,
  input  logic              irqReq,
  output logic              exStart,
  output logic [OPC_W-1:0]  exOpcode,
  output logic [OPD_W-1:0]  exOperand,
  input  logic              exDone,
  output logic [ADDR_W-1:0] pcOut,
  output logic [ADDR_W-1:0] marOut,
  output logic [WORD_W-1:0] mdrOut,
  output logic [WORD_W-1:0] cirOut,
  output logic              irqMasked
);
  seqStrobe_t stb;

  fdsControl #(.OPC_W(OPC_W), .RET_OP(RET_OP)) uCtrl (
    .clk(clk), .rst(rst), .opcode(exOpcode), .exDone(exDone),
    .irqReq(irqReq), .irqMasked(irqMasked), .stb(stb),
    .memRdEn(memRdEn), .exStart(exStart)
  );

  fdsDatapath #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .OPC_W(OPC_W),
                .IRQ_VEC(IRQ_VEC)) uPath (
    .clk(clk), .rst(rst), .stb(stb), .memRdData(memRdData),
    .pc(pcOut), .mar(marOut), .mdr(mdrOut), .cir(cirOut),
    .masked(irqMasked), .opcode(exOpcode), .operand(exOperand)
  );

  assign memAddr = marOut;
endmodule

// File: tb/tb_fetchDecodeSeq.sv
module tb_fetchDecodeSeq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        memRdEn;
  logic [7:0]  memAddr;
  logic [15:0] memRdData = '0;
  logic        irqReq = 1'b0;
  logic        exStart;
  logic [7:0]  exOpcode, exOperand;
  logic        exDone = 1'b0;
  logic [7:0]  pcOut, marOut;
  logic [15:0] mdrOut, cirOut;
  logic        irqMasked;

  int checks = 0;
  int errors = 0;
  int phaseNo = 1;
  int entries = 0;
  logic [15:0] mem [256];
  logic [15:0] expQ [$];

  always #4 clk = ~clk;

  fetchDecodeSeq dut (
    .clk(clk), .rst(rst), .memRdEn(memRdEn), .memAddr(memAddr),
    .memRdData(memRdData), .irqReq(irqReq), .exStart(exStart),
    .exOpcode(exOpcode), .exOperand(exOperand), .exDone(exDone),
    .pcOut(pcOut), .marOut(marOut), .mdrOut(mdrOut), .cirOut(cirOut),
    .irqMasked(irqMasked)
  );

  always @(posedge clk) if (memRdEn) memRdData <= mem[memAddr];

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [15:0] word(input int a);
    logic [7:0] ab = a[7:0];
    return {1'b0, ab[6:0], ab};
  endfunction

  task automatic loadProgram(input bit withReturn);
    for (int a = 0; a < 256; a++) mem[a] = word(a);
    if (withReturn) mem[8'hF1] = 16'hFF00;
  endtask

  task automatic pushExp(input int a);
    expQ.push_back(word(a));
  endtask

  // monitor: scoreboard compare at each start pulse
  always @(negedge clk) begin
    if (!rst && exStart) begin
      if (expQ.size() == 0) begin
        chk("R5 unexpected start", {exOpcode, exOperand}, 32'hDEAD);
      end else begin
        logic [15:0] e;
        e = expQ.pop_front();
        chk("R5 R7 R8 R9 order", {exOpcode, exOperand}, e);
      end
      if (phaseNo == 1 && exOperand == 8'hF0) chk("R7 mask set", irqMasked, 1);
      if (phaseNo == 1 && exOperand == 8'h03) chk("R9 mask clear", irqMasked, 0);
      if (phaseNo == 2 && exOperand == 8'hFF) chk("R3 wrap", pcOut, 0);
    end
  end

  // executor model with interrupt stimulus
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && exStart) begin
        int lat;
        bit dropAfter;
        lat = int'(exOperand[1:0]);
        dropAfter = 1'b0;
        if (phaseNo == 1 && exOperand == 8'h02 && entries == 0) irqReq = 1'b1;
        if (phaseNo == 1 && exOperand == 8'h05 && entries == 1) irqReq = 1'b1;
        if (phaseNo == 1 && exOperand == 8'hF0) begin
          entries++;
          dropAfter = 1'b1;
        end
        @(negedge clk);
        for (int i = 0; i < lat; i++) begin
          chk("R6 no read while executing", memRdEn, 0);
          chk("R6 no second start", exStart, 0);
          @(negedge clk);
        end
        exDone = 1'b1;
        @(negedge clk);
        exDone = 1'b0;
        if (dropAfter) begin
          repeat (3) @(negedge clk);
          irqReq = 1'b0;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    loadProgram(1'b1);
    repeat (3) @(negedge clk);
    chk("R1 pc", pcOut, 0);
    chk("R1 mar", marOut, 0);
    chk("R1 cir", cirOut, 0);
    chk("R1 mask", irqMasked, 0);
    chk("R1 start", exStart, 0);
    foreach (expQ[i]) ;
    pushExp(0); pushExp(1); pushExp(2); pushExp(8'hF0); pushExp(3);
    pushExp(4); pushExp(5); pushExp(8'hF0); pushExp(6); pushExp(7);
    rst = 1'b0;
    @(negedge clk);
    chk("R2 read strobe", memRdEn, 1);
    chk("R2 mar", marOut, 0);
    chk("R3 pc before data", pcOut, 0);
    @(negedge clk);
    chk("R3 pc stepped", pcOut, 1);
    chk("R2 single strobe", memRdEn, 0);
    chk("R4 mdr not yet", mdrOut, 0);
    @(negedge clk);
    chk("R4 mdr", mdrOut, word(0));
    chk("R4 cir not yet", cirOut, 0);
    @(negedge clk);
    chk("R4 cir", cirOut, word(0));
    chk("R5 start", exStart, 1);
    while (expQ.size() != 0) @(negedge clk);
    // phase 2: reset mid-run, then walk through the wrap
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 mdr cleared", mdrOut, 0);
    chk("R1 cir cleared", cirOut, 0);
    chk("R1 pc cleared", pcOut, 0);
    chk("R1 mask cleared", irqMasked, 0);
    phaseNo = 2;
    irqReq = 1'b0;
    loadProgram(1'b0);
    for (int a = 0; a < 259; a++) pushExp(a % 256);
    rst = 1'b0;
    while (expQ.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule